// File: doc/BRIEF.md
# Six-Channel PWM Timer with Buffered Compare Reload

A free-running 16-bit up-counter produces a repeating period whose last count is taken from compare slot 0. Six pulse-width outputs ride on that period: each output is raised when the count equals one compare slot and dropped when it equals another. Software loads thirteen compare slots over a plain write port, then pulses a start input. Starting copies every slot into a working buffer, and the counter and the outputs then act only on the buffered copies.

Compare values can be changed while the timer runs without tearing a period. Software writes slot 0 and slots 2 to 12 first, then writes slot 1 last. Writing slot 1 raises a pending flag, and at the next period end all thirteen buffers are refreshed together and the flag drops. Every compare match also produces a one-cycle interrupt pulse: one vector for the set matches, one for the clear matches, one for the period match, and a period-end pulse that is gated by an enable input.

Top module: `pwm6_timer`

## Requirements
- R1: While running, `count_o` steps by one each cycle from 0 up to the buffered period value (slot 0), then returns to 0 on the next cycle. The period is therefore slot0+1 cycles.
- R2: A `start_i` pulse while stopped (and with `stop_i` low) copies all thirteen slots into the buffers, sets the count to 0 and clears `reload_pend_o`. While running, `start_i` has no effect.
- R3: Output j (j = 0..5, bit j of `pwm_o`) goes high one cycle after the count equals buffered slot 2j+2.
- R4: Output j goes low one cycle after the count equals buffered slot 2j+1.
- R5: If the set slot and the clear slot of an output hold the same value, the output goes or stays low at that count. A slot value above the buffered period never matches.
- R6: A write to slot 1 (address 1) sets `reload_pend_o` in the next cycle. The flag stays at 1 until the period match, then drops in the same cycle that `irq_prd_o` pulses.
- R7: Writes to the slots do not change any buffered value before the next reload. At a period match with the flag set, all thirteen buffers take the current slot contents, and the new values govern the counts from the next period onward.
- R8: `irq_set_o[j]`, `irq_clr_o[j]` and `irq_prd_o` are registered single-cycle pulses, high one cycle after the count equals buffered slot 2j+2, slot 2j+1 and slot 0 respectively.
- R9: `irq_pe_o` pulses with `irq_prd_o` only when `pe_irq_en_i` was high in the match cycle.
- R10: A `stop_i` pulse halts the counter at 0 and drives all outputs and interrupts low in the next cycle. `stop_i` overrides `start_i`, and the pending flag is left unchanged.
- R11: The write address selects slot 0..12. A write to any other address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Slot write strobe |
| wr_addr_i | input | 4 | Slot index 0..12 |
| wr_data_i | input | 16 | Slot write value |
| start_i | input | 1 | Start pulse |
| stop_i | input | 1 | Stop pulse, overrides start |
| pe_irq_en_i | input | 1 | Enables the period-end interrupt |
| count_o | output | 16 | Current count |
| pwm_o | output | 6 | PWM outputs, active high |
| reload_pend_o | output | 1 | Reload armed and not yet done |
| irq_set_o | output | 6 | Set-match pulses per output |
| irq_clr_o | output | 6 | Clear-match pulses per output |
| irq_prd_o | output | 1 | Period-match pulse |
| irq_pe_o | output | 1 | Gated period-end pulse |

## Verification
The hardest situation to reach is a reload that lands while a period is in flight. This covers slot writes made while the flag is already set, a new period that is shorter or longer than the old one, and coincident set and clear values. Only the relative order of writes against the period boundary brings these about. The bench runs a reference model beside the design that compares every output every cycle. It rewrites slots at chosen counts in the middle of a period, then sweeps every pair of set and clear values from 0 to one past the period over several short periods, so ties, zero values and out-of-range values all occur.

// File: rtl/pwm6_pkg.sv
package pwm6_pkg;
  localparam int unsigned CNT_W_DEF = 16;
  localparam int unsigned N_CH_DEF  = 6;

  function automatic int unsigned n_slots(input int unsigned n_ch);
    return 2 * n_ch + 1;
  endfunction

  function automatic int unsigned set_slot(input int unsigned ch);
    return 2 * ch + 2;
  endfunction

  function automatic int unsigned clr_slot(input int unsigned ch);
    return 2 * ch + 1;
  endfunction
endpackage

// File: rtl/pwm6_cmp_bank.sv
module pwm6_cmp_bank #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned N_SLOT = 13,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic              load_i,
  input  logic              wrap_i,
  output logic [CNT_W-1:0]  buf_o [N_SLOT],
  output logic              pend_o
);
  logic [CNT_W-1:0] slot_q [N_SLOT];
  logic             arm_wr;
  logic             reload;

  assign arm_wr = wr_en_i && (wr_addr_i == ADDR_W'(1));
  assign reload = load_i || (wrap_i && pend_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N_SLOT; k++) begin
        slot_q[k] <= '0;
        buf_o[k]  <= '0;
      end
    end else begin
      for (int k = 0; k < N_SLOT; k++) begin
        if (wr_en_i && (wr_addr_i == ADDR_W'(k))) slot_q[k] <= wr_data_i;
        if (reload) buf_o[k] <= slot_q[k];
      end
    end
  end

  // start clears; a fresh arm beats a same-cycle wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_o <= 1'b0;
    else if (load_i) pend_o <= 1'b0;
    else if (arm_wr) pend_o <= 1'b1;
    else if (wrap_i) pend_o <= 1'b0;
  end
endmodule

// File: rtl/pwm6_counter.sv
module pwm6_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [CNT_W-1:0] prd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             active_o,
  output logic             wrap_o,
  output logic             load_o
);
  logic running_q;

  assign active_o = running_q && !stop_i;
  assign wrap_o   = active_o && (cnt_o == prd_i);
  assign load_o   = start_i && !stop_i && !running_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      cnt_o     <= '0;
    end else if (stop_i) begin
      running_q <= 1'b0;
      cnt_o     <= '0;
    end else if (load_o) begin
      running_q <= 1'b1;
      cnt_o     <= '0;
    end else if (active_o) begin
      cnt_o <= wrap_o ? '0 : cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/pwm6_channel.sv
module pwm6_channel #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] set_val_i,
  input  logic [CNT_W-1:0] clr_val_i,
  output logic             pwm_o,
  output logic             set_irq_o,
  output logic             clr_irq_o
);
  logic set_hit, clr_hit;

  // count never exceeds the period, so out-of-range values cannot match
  assign set_hit = active_i && (cnt_i == set_val_i);
  assign clr_hit = active_i && (cnt_i == clr_val_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwm_o     <= 1'b0;
      set_irq_o <= 1'b0;
      clr_irq_o <= 1'b0;
    end else begin
      set_irq_o <= set_hit;
      clr_irq_o <= clr_hit;
      if (!active_i)    pwm_o <= 1'b0;
      else if (clr_hit) pwm_o <= 1'b0;
      else if (set_hit) pwm_o <= 1'b1;
    end
  end
endmodule

// File: rtl/pwm6_timer.sv
module pwm6_timer #(
  parameter int unsigned CNT_W  = pwm6_pkg::CNT_W_DEF,
  parameter int unsigned N_CH   = pwm6_pkg::N_CH_DEF,
  parameter int unsigned ADDR_W = $clog2(2 * N_CH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              pe_irq_en_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [N_CH-1:0]   pwm_o,
  output logic              reload_pend_o,
  output logic [N_CH-1:0]   irq_set_o,
  output logic [N_CH-1:0]   irq_clr_o,
  output logic              irq_prd_o,
  output logic              irq_pe_o
);
  localparam int unsigned N_SLOT = pwm6_pkg::n_slots(N_CH);

  logic [CNT_W-1:0] buf_q [N_SLOT];
  logic             active, wrap, load;

  pwm6_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
    .prd_i(buf_q[0]), .cnt_o(count_o), .active_o(active), .wrap_o(wrap),
    .load_o(load)
  );

  pwm6_cmp_bank #(.CNT_W(CNT_W), .N_SLOT(N_SLOT), .ADDR_W(ADDR_W)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .load_i(load), .wrap_i(wrap), .buf_o(buf_q),
    .pend_o(reload_pend_o)
  );

  for (genvar j = 0; j < N_CH; j++) begin : g_ch
    pwm6_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i(clk_i), .rst_ni(rst_ni), .active_i(active), .cnt_i(count_o),
      .set_val_i(buf_q[pwm6_pkg::set_slot(j)]),
      .clr_val_i(buf_q[pwm6_pkg::clr_slot(j)]),
      .pwm_o(pwm_o[j]), .set_irq_o(irq_set_o[j]), .clr_irq_o(irq_clr_o[j])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_prd_o <= 1'b0;
      irq_pe_o  <= 1'b0;
    end else begin
      irq_prd_o <= wrap;
      irq_pe_o  <= wrap && pe_irq_en_i;
    end
  end
endmodule

// File: rtl/pwm6_timer_chk.sv
module pwm6_timer_chk #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned N_CH  = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             stop_i,
  input logic [CNT_W-1:0] count_o,
  input logic [N_CH-1:0]  pwm_o,
  input logic             reload_pend_o,
  input logic [N_CH-1:0]  irq_set_o,
  input logic [N_CH-1:0]  irq_clr_o,
  input logic             irq_prd_o,
  input logic             irq_pe_o
);
  p_wrap_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_prd_o |-> count_o == '0);

  p_set_drives_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_set_o & ~irq_clr_o & ~pwm_o) == '0);

  p_clr_drives_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_o & pwm_o) == '0);

  p_pend_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(reload_pend_o) |-> (irq_prd_o || $past(start_i)));

  p_pe_gated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_pe_o |-> irq_prd_o);

  p_stop_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (count_o == '0 && pwm_o == '0 && !irq_prd_o));
endmodule

bind pwm6_timer pwm6_timer_chk #(.CNT_W(CNT_W), .N_CH(N_CH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
  .count_o(count_o), .pwm_o(pwm_o), .reload_pend_o(reload_pend_o),
  .irq_set_o(irq_set_o), .irq_clr_o(irq_clr_o), .irq_prd_o(irq_prd_o),
  .irq_pe_o(irq_pe_o)
);

// File: tb/pwm6_timer_tb.sv
module pwm6_timer_tb;
  localparam int NS = 13;
  localparam int NC = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        start = 1'b0, stop = 1'b0, pe_en = 1'b0;
  logic [15:0] count;
  logic [5:0]  pwm, irq_set, irq_clr;
  logic        pend, irq_prd, irq_pe;

  always #5 clk = ~clk;

  pwm6_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .start_i(start), .stop_i(stop), .pe_irq_en_i(pe_en),
    .count_o(count), .pwm_o(pwm), .reload_pend_o(pend), .irq_set_o(irq_set),
    .irq_clr_o(irq_clr), .irq_prd_o(irq_prd), .irq_pe_o(irq_pe)
  );

  // reference model built from the requirements
  logic [15:0] m_slot [NS];
  logic [15:0] m_buf  [NS];
  logic        m_run, m_pend, m_prd, m_pe;
  logic [15:0] m_cnt;
  logic [5:0]  m_pwm, m_set, m_clr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NS; k++) begin m_slot[k] = '0; m_buf[k] = '0; end
      m_run = 0; m_pend = 0; m_prd = 0; m_pe = 0; m_cnt = '0;
      m_pwm = '0; m_set = '0; m_clr = '0;
    end else begin
      logic act, wrp, ld, rel;
      logic [15:0] old_slot [NS];
      act = m_run && !stop;
      wrp = act && (m_cnt == m_buf[0]);
      ld  = start && !stop && !m_run;
      rel = ld || (wrp && m_pend);
      for (int k = 0; k < NS; k++) old_slot[k] = m_slot[k];
      for (int j = 0; j < NC; j++) begin
        logic sh, ch;
        sh = act && (m_cnt == m_buf[2*j+2]) && (m_buf[2*j+2] <= m_buf[0]);
        ch = act && (m_cnt == m_buf[2*j+1]) && (m_buf[2*j+1] <= m_buf[0]);
        m_set[j] = sh; m_clr[j] = ch;
        if (!act) m_pwm[j] = 0;
        else if (ch) m_pwm[j] = 0;
        else if (sh) m_pwm[j] = 1;
      end
      m_prd = wrp; m_pe = wrp && pe_en;
      if (ld) m_pend = 0;
      else if (wr_en && wr_addr == 4'd1) m_pend = 1;
      else if (wrp) m_pend = 0;
      if (wr_en && wr_addr < 4'd13) m_slot[wr_addr] = wr_data;
      if (rel) for (int k = 0; k < NS; k++) m_buf[k] = old_slot[k];
      if (stop) begin m_run = 0; m_cnt = '0; end
      else if (ld) begin m_run = 1; m_cnt = '0; end
      else if (act) m_cnt = wrp ? '0 : m_cnt + 16'd1;
    end
  end

  int vectors = 0, errors = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
    vectors++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act_v, exp_v);
    end
  endtask

  task automatic compare_all();
    chk("R1 count", 32'(count), 32'(m_cnt));
    chk("R3/R4/R5/R10 pwm", 32'(pwm), 32'(m_pwm));
    chk("R6 pend", 32'(pend), 32'(m_pend));
    chk("R8 irq_set", 32'(irq_set), 32'(m_set));
    chk("R8 irq_clr", 32'(irq_clr), 32'(m_clr));
    chk("R8 irq_prd", 32'(irq_prd), 32'(m_prd));
    chk("R9 irq_pe", 32'(irq_pe), 32'(m_pe));
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1; wr_addr = 4'(a); wr_data = 16'(d);
    tick();
    wr_en = 0;
  endtask

  task automatic pulse_start(); start = 1; tick(); start = 0; endtask
  task automatic pulse_stop();  stop = 1;  tick(); stop = 0;  endtask

  // wait until the count reads v at a negedge
  task automatic wait_cnt(input int v);
    for (int i = 0; i < 1000; i++) begin
      if (count == 16'(v)) break;
      tick();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R10 reset pwm", 32'(pwm), 0);
    chk("R1 reset count", 32'(count), 0);
    chk("R6 reset pend", 32'(pend), 0);
    rst_n = 1;
    tick();

    // directed: period 9, mixed channels incl. tie, zero, out-of-range
    wr(0, 9);
    wr(2, 1);  wr(1, 5);   // ch0 high 2..6
    wr(4, 0);  wr(3, 9);   // ch1 set at 0, clear at period
    wr(6, 4);  wr(5, 4);   // ch2 tie -> stays low (R5)
    wr(8, 3);  wr(7, 12);  // ch3 clear out of range (R5)
    wr(10, 12); wr(9, 2);  // ch4 set out of range
    wr(12, 7); wr(11, 2);  // ch5 wraps across period
    wr(14, 3);             // R11 unmapped address
    pe_en = 1;
    pulse_start();         // R2 clears the armed flag
    chk("R2 pend cleared by start", 32'(pend), 0);
    tick(25);
    pe_en = 0; tick(12);   // R9 gating
    pe_en = 1;

    // R7: rewrite mid-period, flag arming, writes while pending
    wait_cnt(3);
    wr(0, 5); wr(2, 0); wr(12, 1);
    wr(1, 3);              // arm (R6)
    chk("R6 pend armed", 32'(pend), 1);
    wr(4, 2);              // written while pending, lands at same reload
    tick(30);
    wait_cnt(2);
    wr(0, 14); wr(1, 10);  // longer period
    tick(40);

    // R10: stop overrides start, then restart
    wait_cnt(4);
    stop = 1; start = 1; tick(); stop = 0; start = 0;
    chk("R10 stopped count", 32'(count), 0);
    tick(5);
    chk("R10 idle pwm", 32'(pwm), 0);
    pulse_start(); tick(3);
    start = 1; tick(4); start = 0;    // R2 start ignored while running
    tick(10);
    pulse_stop();

    // sweep set/clear on ch0 over short periods
    for (int p = 1; p <= 7; p++) begin
      for (int s = 0; s <= p + 1; s++) begin
        for (int c = 0; c <= p + 1; c++) begin
          wr(0, p); wr(2, s); wr(1, c);
          for (int k = 3; k < NS; k++) wr(k, p + 1 + k);
          pulse_start();
          tick(2 * p + 4);
          pulse_stop();
        end
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule